// File: doc/BRIEF.md
# Four-Channel Byte-Mover DMA Engine

This block moves bytes between any two addresses of a shared 24-bit, 8-bit-data bus on behalf of four independent channels. There is no split between peripheral register space and memory inside the engine. A peripheral-to-memory, memory-to-memory or register-to-register copy is just a pair of source and destination addresses and stepping rules. Each channel keeps its own start addresses, its stepping modes, a block length and a count of blocks. The whole transfer is block length times block count, up to 16 MiB.

A channel starts work when software pulses its start bit or when a chosen event strobe fires. Either one byte or one whole block is moved per trigger. The engine raises its bus request whenever it holds work. Each read beat and write beat completes only in a cycle where the grant is high, so the processor keeps the bus whenever it holds it. When a channel moves its final byte, it drops its enable and raises a sticky done flag. A trigger that arrives while earlier work is still pending raises a sticky overrun flag.

The control path is a three-state sequencer: `ST_IDLE`, `ST_READ` and `ST_WRITE`.
- `ST_IDLE` to `ST_READ`: a channel is pending; the arbiter picks it.
- `ST_READ` holds until grant. On grant it captures the read data and moves to `ST_WRITE`.
- `ST_WRITE` holds until grant. On grant it goes back to `ST_READ` if the channel is in block mode and the block is not finished. Otherwise it returns to `ST_IDLE`.

Top module: `dma_engine`

## Requirements
- R1: After reset, `bus_req`, `bus_rd` and `bus_wr` are low, and all enable, done and overrun flags are zero.
- R2: `bus_req` is high whenever the sequencer holds a byte in flight. A beat completes only at a clock edge where `bus_gnt` is high. While the grant is low, the address and strobes hold their values.
- R3: Each byte is a read beat at the current source address (`bus_rd` high) followed by a write beat at the current destination address (`bus_wr` high) carrying the byte just read.
- R4: Control bits [2:1] set the source stepping and bits [5:4] set the destination stepping: 0 is fixed, 1 adds one per byte, 2 subtracts one per byte.
- R5: Control bit 3 (source) and bit 6 (destination) reload the start address after the last byte of every block, in place of the step. When the bit is clear, the address keeps stepping across blocks.
- R6: A transfer moves block length times block count bytes (both fields at least 1). After the final byte, the channel's enable reads 0 and its done flag reads 1.
- R7: Writing selector 6 with bit i set starts channel i. Control field [10:8] = k (1..4) also starts the channel on each pulse of `evt_i[k-1]`, and k = 0 means software only.
- R8: Control bit 7 = 0 moves one byte per trigger. Bit 7 = 1 moves a whole block per trigger.
- R9: A trigger to a channel whose earlier trigger is still pending sets its sticky overrun flag. Writing the channel's control register clears both the done and overrun flags.
- R10: With round-robin off (selector 5 bit 0 = 0), among channels pending together the lowest channel number is served first.
- R11: With round-robin on, when only channels 2 and 3 are pending together, the one not served most recently between them goes first.
- R12: Triggers, software or event, to a channel whose enable bit is 0 cause no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 3 | 0 src start, 1 dst start, 2 block length, 3 block count, 4 control, 5 global (bit0 round-robin), 6 start bits |
| cfg_wdata | input | 24 | Write data |
| evt_i | input | 4 | Event strobes |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_rd | output | 1 | Read beat strobe |
| bus_wr | output | 1 | Write beat strobe |
| bus_addr | output | 24 | Beat address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the read beat cycle |
| en_o | output | 4 | Per-channel enable |
| done_o | output | 4 | Per-channel sticky done |
| ovr_o | output | 4 | Per-channel sticky overrun |

## Verification
The bench builds the engine with its default parameters: four channels, 24-bit addresses, 16-bit block length, 8-bit block count and four event lines. Short blocks and small repeat counts bring every block-end reload and stepping combination within a few dozen cycles. Four channels make both the fixed-priority order and the round-robin pairing of channels 2 and 3 reachable. The grant is withheld or chopped at times, which exercises stalls between a read beat and its write beat.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_st_t;

    typedef enum logic [1:0] {
        AM_FIXED = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_HOLD  = 2'd3
    } amode_t;

    // control word, MSB first: [10:8] event select, [7] block mode,
    // [6] dst reload, [5:4] dst mode, [3] src reload, [2:1] src mode, [0] enable
    typedef struct packed {
        logic [2:0] evsel;
        logic       blk_mode;
        logic       dst_rel;
        amode_t     dst_mode;
        logic       src_rel;
        amode_t     src_mode;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [2:0] SEL_SRC   = 3'd0;
    localparam logic [2:0] SEL_DST   = 3'd1;
    localparam logic [2:0] SEL_BLK   = 3'd2;
    localparam logic [2:0] SEL_RPT   = 3'd3;
    localparam logic [2:0] SEL_CTRL  = 3'd4;
    localparam logic [2:0] SEL_GLOB  = 3'd5;
    localparam logic [2:0] SEL_START = 3'd6;

endpackage

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW  = 24,
    parameter int BW  = 16,
    parameter int RW  = 8,
    parameter int NEV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          sw_go,
    input  logic [NEV-1:0] evt_i,
    input  logic          step,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic          pend_o,
    output logic          en_o,
    output logic          done_o,
    output logic          ovr_o,
    output logic          blk_last_o,
    output logic          byte_mode_o
);

    ctrl_t         ctrl;
    logic [AW-1:0] src_start, dst_start, src_cur, dst_cur;
    logic [BW-1:0] blk_size, blk_left;
    logic [RW-1:0] rpt, rpt_left;
    logic          pend, done, ovr;
    logic [7:0]    evt_ext;
    logic          trig, blk_end, last_all, clr;

    assign evt_ext  = 8'({evt_i, 1'b0});
    assign trig     = ctrl.en && (sw_go || evt_ext[ctrl.evsel]);
    assign blk_end  = (blk_left == BW'(1));
    assign last_all = blk_end && (rpt_left == RW'(1));
    assign clr      = step && (blk_end || !ctrl.blk_mode);

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input amode_t m);
        case (m)
            AM_INC:  return a + AW'(1);
            AM_DEC:  return a - AW'(1);
            default: return a;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            src_start <= '0;
            dst_start <= '0;
            src_cur   <= '0;
            dst_cur   <= '0;
            blk_size  <= '0;
            blk_left  <= '0;
            rpt       <= '0;
            rpt_left  <= '0;
            pend      <= 1'b0;
            done      <= 1'b0;
            ovr       <= 1'b0;
        end else if (cfg_we && cfg_sel == SEL_CTRL) begin
            ctrl     <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            src_cur  <= src_start;
            dst_cur  <= dst_start;
            blk_left <= blk_size;
            rpt_left <= rpt;
            pend     <= 1'b0;
            done     <= 1'b0;
            ovr      <= 1'b0;
        end else begin
            if (cfg_we && cfg_sel == SEL_SRC) src_start <= cfg_wdata;
            if (cfg_we && cfg_sel == SEL_DST) dst_start <= cfg_wdata;
            if (cfg_we && cfg_sel == SEL_BLK) blk_size  <= cfg_wdata[BW-1:0];
            if (cfg_we && cfg_sel == SEL_RPT) rpt       <= cfg_wdata[RW-1:0];
            if (step) begin
                if (blk_end) begin
                    blk_left <= blk_size;
                    rpt_left <= rpt_left - RW'(1);
                    src_cur  <= ctrl.src_rel ? src_start : nxt(src_cur, ctrl.src_mode);
                    dst_cur  <= ctrl.dst_rel ? dst_start : nxt(dst_cur, ctrl.dst_mode);
                end else begin
                    blk_left <= blk_left - BW'(1);
                    src_cur  <= nxt(src_cur, ctrl.src_mode);
                    dst_cur  <= nxt(dst_cur, ctrl.dst_mode);
                end
                if (last_all) begin
                    ctrl.en <= 1'b0;
                    done    <= 1'b1;
                end
            end
            if (step && last_all) pend <= 1'b0;
            else                  pend <= (pend && !clr) || trig;
            ovr <= ovr | (trig && pend && !clr);
        end
    end

    assign src_o       = src_cur;
    assign dst_o       = dst_cur;
    assign pend_o      = pend;
    assign en_o        = ctrl.en;
    assign done_o      = done;
    assign ovr_o       = ovr;
    assign blk_last_o  = blk_end;
    assign byte_mode_o = !ctrl.blk_mode;

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
    parameter int NCH = 4,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend,
    input  logic           rr_en,
    input  logic           take,
    output logic           any,
    output logic [CHW-1:0] win
);

    logic [CHW-1:0] fixed_win;

    always_comb begin
        fixed_win = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) fixed_win = CHW'(i);
        end
    end

    assign any = |pend;

    generate
        if (NCH >= 4) begin : g_rr
            logic last_was2;
            logic pair_only;
            assign pair_only = rr_en && pend[2] && pend[3] && !pend[0] && !pend[1];
            assign win = pair_only ? (last_was2 ? CHW'(3) : CHW'(2)) : fixed_win;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    last_was2 <= 1'b0;
                end else if (take && (win == CHW'(2) || win == CHW'(3))) begin
                    last_was2 <= (win == CHW'(2));
                end
            end
        end else begin : g_fixed
            assign win = fixed_win;
        end
    endgenerate

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 24,
    parameter int DW  = 8,
    parameter int BW  = 16,
    parameter int RW  = 8,
    parameter int NEV = 4,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [2:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic [NEV-1:0] evt_i,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] en_o,
    output logic [NCH-1:0] done_o,
    output logic [NCH-1:0] ovr_o
);

    seq_st_t        state, state_nx;
    logic [CHW-1:0] cur;
    logic [DW-1:0]  rbuf;
    logic           rr_en;
    logic           any, take;
    logic [CHW-1:0] win;
    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    logic [NCH-1:0] pend, blk_last, byte_mode, step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              rr_en <= 1'b0;
        else if (cfg_we && cfg_sel == SEL_GLOB)  rr_en <= cfg_wdata[0];
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            dma_chan #(.AW(AW), .BW(BW), .RW(RW), .NEV(NEV)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .cfg_we     (cfg_we && cfg_ch == CHW'(i)),
                .cfg_sel    (cfg_sel),
                .cfg_wdata  (cfg_wdata),
                .sw_go      (cfg_we && cfg_sel == SEL_START && cfg_wdata[i]),
                .evt_i      (evt_i),
                .step       (step[i]),
                .src_o      (src_a[i]),
                .dst_o      (dst_a[i]),
                .pend_o     (pend[i]),
                .en_o       (en_o[i]),
                .done_o     (done_o[i]),
                .ovr_o      (ovr_o[i]),
                .blk_last_o (blk_last[i]),
                .byte_mode_o(byte_mode[i])
            );
            assign step[i] = (state == ST_WRITE) && bus_gnt && (cur == CHW'(i));
        end
    endgenerate

    dma_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .pend (pend),
        .rr_en(rr_en),
        .take (take),
        .any  (any),
        .win  (win)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur   <= '0;
            rbuf  <= '0;
        end else begin
            state <= state_nx;
            if (take)                           cur  <= win;
            if (state == ST_READ && bus_gnt)    rbuf <= bus_rdata;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        take     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (any) begin
                    take     = 1'b1;
                    state_nx = ST_READ;
                end
            end
            ST_READ: begin
                if (bus_gnt) state_nx = ST_WRITE;
            end
            ST_WRITE: begin
                if (bus_gnt) begin
                    state_nx = (blk_last[cur] || byte_mode[cur]) ? ST_IDLE : ST_READ;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = (state != ST_IDLE);
        bus_rd    = (state == ST_READ);
        bus_wr    = (state == ST_WRITE);
        bus_addr  = (state == ST_WRITE) ? dst_a[cur] : src_a[cur];
        bus_wdata = rbuf;
    end

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int NCH = 4,
    parameter int AW  = 24
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_gnt,
    input logic           bus_rd,
    input logic           bus_wr,
    input logic [AW-1:0]  bus_addr,
    input logic [NCH-1:0] en_o,
    input logic [NCH-1:0] done_o
);

    p_beat_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> bus_req);

    p_hold_no_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> ($stable(bus_addr) && $stable(bus_rd) && $stable(bus_wr)));

    p_one_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr}));

    p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_gnt) |=> bus_wr);

    p_done_drops_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_o & ~$past(done_o) & en_o) == '0));

endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_req (bus_req),
    .bus_gnt (bus_gnt),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .en_o    (en_o),
    .done_o  (done_o)
);

// File: tb/sim_dma_engine.sv
module sim_dma_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [2:0]  cfg_sel = '0;
    logic [23:0] cfg_wdata = '0;
    logic [3:0]  evt_i = '0;
    logic        bus_req, bus_rd, bus_wr;
    logic        bus_gnt = 1'b0;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [3:0]  en_o, done_o, ovr_o;

    always #2 clk = ~clk;

    dma_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .evt_i(evt_i), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .en_o(en_o), .done_o(done_o), .ovr_o(ovr_o)
    );

    logic [7:0]  mem [256];
    logic [23:0] log_addr [256];
    logic [7:0]  log_data [256];
    int          log_n = 0;
    int          gmode = 0;   // 0 grant always, 1 chopped grant, 2 no grant
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 0;

    assign bus_rdata = mem[bus_addr[7:0]];

    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

    // grant model and write-beat logger
    always @(negedge clk) begin
        logic g;
        cyc++;
        g = (gmode == 0) ? 1'b1 : (gmode == 1) ? (cyc % 3 != 0) : 1'b0;
        bus_gnt = g;
        if (bus_wr && g && log_n < 256) begin
            log_addr[log_n] = bus_addr;
            log_data[log_n] = bus_wdata;
            mem[bus_addr[7:0]] = bus_wdata;
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [2:0] sel, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int line);
        @(negedge clk); evt_i = 4'(1 << line);
        @(negedge clk); evt_i = '0;
    endtask

    function automatic logic [23:0] mk(input bit en, input logic [1:0] sm, input bit sr,
                                       input logic [1:0] dm, input bit dr, input bit blk,
                                       input logic [2:0] ev);
        return 24'({ev, blk, dr, dm, sr, sm, en});
    endfunction

    function automatic logic [7:0] stp(input logic [7:0] a, input logic [1:0] m);
        return (m == 2'd1) ? a + 8'd1 : (m == 2'd2) ? a - 8'd1 : a;
    endfunction

    task automatic setup(input int ch, input logic [7:0] s, input logic [7:0] d,
                         input int blk, input int rpt, input logic [23:0] ctl);
        wr(ch, 3'd0, {16'h0, s});
        wr(ch, 3'd1, {16'h0, d});
        wr(ch, 3'd2, 24'(blk));
        wr(ch, 3'd3, 24'(rpt));
        wr(ch, 3'd4, ctl);
    endtask

    typedef struct packed {
        logic [7:0] src;
        logic [7:0] dst;
        logic [1:0] sm;
        logic       sr;
        logic [1:0] dm;
        logic       dr;
        logic [3:0] blk;
        logic [3:0] rpt;
        logic       stall;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'h10, 8'h80, 2'd1, 1'b0, 2'd1, 1'b0, 4'd4, 4'd1, 1'b0},
        '{8'h20, 8'h90, 2'd2, 1'b0, 2'd0, 1'b0, 4'd3, 4'd2, 1'b1},
        '{8'h30, 8'hA0, 2'd0, 1'b0, 2'd1, 1'b0, 4'd2, 4'd3, 1'b0},
        '{8'h40, 8'hB0, 2'd1, 1'b1, 2'd2, 1'b1, 4'd3, 4'd2, 1'b1},
        '{8'h50, 8'hC0, 2'd2, 1'b1, 2'd1, 1'b1, 4'd2, 4'd2, 1'b0}
    };

    initial begin
        int base;
        idle(3);
        // R1 reset state
        chk(!bus_req && !bus_rd && !bus_wr, "R1 bus idle", {bus_req, bus_rd, bus_wr}, 0);
        chk(en_o == 0 && done_o == 0 && ovr_o == 0, "R1 flags", {en_o, done_o, ovr_o}, 0);
        rst_n = 1'b1;
        idle(2);
        chk(!bus_req, "R1 no request after reset", bus_req, 0);

        // table of block transfers on channel 0 (R3 R4 R5 R6, R2 under chopped grant)
        foreach (VECS[v]) begin
            vec_t t;
            int bad;
            logic [7:0] s, d;
            t = VECS[v];
            gmode = t.stall ? 1 : 0;
            setup(0, t.src, t.dst, int'(t.blk), int'(t.rpt), mk(1, t.sm, t.sr, t.dm, t.dr, 1, 0));
            base = log_n;
            for (int b = 0; b < int'(t.rpt); b++) begin
                int to = 0;
                wr(0, 3'd6, 24'h1);
                while (log_n < base + int'(t.blk) * (b + 1) && to < 500) begin
                    @(negedge clk); to++;
                end
                idle(2);
            end
            idle(3);
            chk(log_n - base == int'(t.blk) * int'(t.rpt), "R6 R2 byte count",
                log_n - base, int'(t.blk) * int'(t.rpt));
            chk(en_o[0] == 0 && done_o[0] == 1, "R6 enable cleared and done set",
                {en_o[0], done_o[0]}, 2'b01);
            bad = 0; s = t.src; d = t.dst;
            for (int k = 0; k < int'(t.blk) * int'(t.rpt); k++) begin
                if (base + k >= log_n || log_addr[base + k] != {16'h0, d} ||
                    log_data[base + k] != (s ^ 8'h5A)) bad++;
                if ((k % int'(t.blk)) == int'(t.blk) - 1) begin
                    s = t.sr ? t.src : stp(s, t.sm);
                    d = t.dr ? t.dst : stp(d, t.dm);
                end else begin
                    s = stp(s, t.sm);
                    d = stp(d, t.dm);
                end
            end
            chk(bad == 0, "R3 R4 R5 address and data sequence", bad, 0);
        end
        gmode = 0;

        // R12 disabled channel ignores triggers
        setup(1, 8'h60, 8'hD0, 2, 1, mk(0, 1, 0, 1, 0, 1, 3'd1));
        base = log_n;
        pulse(0);
        wr(0, 3'd6, 24'h2);
        idle(8);
        chk(log_n == base && !bus_req, "R12 disabled channel stays quiet", log_n - base, 0);

        // R7 event select
        setup(1, 8'h60, 8'hD0, 2, 1, mk(1, 1, 0, 1, 0, 1, 3'd2));
        base = log_n;
        pulse(0);
        idle(8);
        chk(log_n == base, "R7 unselected event line ignored", log_n - base, 0);
        pulse(1);
        idle(12);
        chk(log_n - base == 2 && done_o[1], "R7 selected event runs block",
            log_n - base, 2);

        // R8 one byte per trigger
        setup(1, 8'h60, 8'hD4, 3, 1, mk(1, 1, 0, 1, 0, 0, 3'd2));
        base = log_n;
        pulse(1);
        idle(10);
        chk(log_n - base == 1 && en_o[1], "R8 one byte per trigger", log_n - base, 1);
        pulse(1); idle(10);
        pulse(1); idle(10);
        chk(log_n - base == 3 && done_o[1] && !en_o[1], "R8 third trigger finishes",
            log_n - base, 3);

        // R9 overrun
        gmode = 2;
        setup(2, 8'h70, 8'hE0, 2, 1, mk(1, 1, 0, 1, 0, 1, 3'd0));
        base = log_n;
        wr(0, 3'd6, 24'h4);
        idle(3);
        chk(ovr_o[2] == 0, "R9 no overrun on first trigger", ovr_o[2], 0);
        wr(0, 3'd6, 24'h4);
        idle(1);
        chk(ovr_o[2] == 1, "R9 overrun on second trigger", ovr_o[2], 1);
        gmode = 0;
        idle(12);
        chk(log_n - base == 2 && done_o[2] && ovr_o[2], "R9 block completes, flag sticky",
            log_n - base, 2);
        wr(2, 3'd4, mk(0, 0, 0, 0, 0, 0, 0));
        idle(1);
        chk(ovr_o[2] == 0 && done_o[2] == 0, "R9 control write clears flags",
            {ovr_o[2], done_o[2]}, 0);

        // R10 fixed priority
        gmode = 2;
        setup(1, 8'h61, 8'hD1, 1, 1, mk(1, 0, 0, 0, 0, 1, 0));
        setup(0, 8'h62, 8'hD8, 1, 1, mk(1, 0, 0, 0, 0, 1, 0));
        base = log_n;
        wr(0, 3'd6, 24'h3);
        gmode = 0;
        idle(12);
        chk(log_n - base == 2 && log_addr[base] == 24'hD8 && log_addr[base + 1] == 24'hD1,
            "R10 channel 0 first", log_addr[base], 24'hD8);

        // R11 round-robin between 2 and 3
        wr(0, 3'd5, 24'h1);
        setup(2, 8'h63, 8'hE8, 2, 1, mk(1, 1, 0, 1, 0, 0, 0));
        setup(3, 8'h64, 8'hF0, 2, 1, mk(1, 1, 0, 1, 0, 0, 0));
        base = log_n;
        wr(0, 3'd6, 24'h4);
        idle(8);
        chk(log_n - base == 1 && log_addr[base] == 24'hE8, "R11 channel 2 served alone",
            log_addr[base], 24'hE8);
        gmode = 2;
        wr(0, 3'd6, 24'hC);
        gmode = 0;
        idle(12);
        chk(log_n - base == 3 && log_addr[base + 1] == 24'hF0 && log_addr[base + 2] == 24'hE9,
            "R11 channel 3 goes first after 2", log_addr[base + 1], 24'hF0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule